// File: doc/BRIEF.md
# Integer ALU with Flag Register and Branch Condition Unit

This block is the execute-stage arithmetic core of a small 32-bit processor. It takes a 4-bit operation selector and two register operands, called A (the source) and B (the destination). It returns the operation result in the same cycle. When asked, it captures three status flags from that result on the next clock edge: signed overflow, zero and negative.

A separate 4-bit branch selector is evaluated against the stored flags, not the flags being computed. A compare-and-branch sequence therefore spans two cycles. An arithmetic operation with flag capture enabled comes first, and the branch decision is read on a later cycle.

The flag register has two named conditions, HOLD and CAPTURE. CAPTURE happens on a clock edge when the capture enable is high and the operation selector is valid. HOLD happens on every other edge.

Top module: `alu_cc_unit`

## Requirements
- R1: Operation selector 0 gives result = B + A, modulo 2^32.
- R2: Operation selector 1 gives result = B - A, modulo 2^32.
- R3: Operation selector 2 gives result = B AND A, and selector 3 gives result = B XOR A.
- R4: Any operation selector from 4 to 15 gives result 0 and leaves all three flags unchanged, even when capture is enabled.
- R5: On a clock edge with capture enabled and selector 0 to 3, the zero flag becomes (result == 0) and the negative flag becomes result bit 31.
- R6: On a capture with selector 0 or 1, the overflow flag records two's-complement signed overflow of that add or subtract. On a capture with selector 2 or 3, the overflow flag is cleared.
- R7: Reset (rst_n low, asynchronous) sets zero = 1, negative = 0 and overflow = 0.
- R8: The branch output is a function of the stored flags and the branch selector. Selector 0 is always taken. 1 is (neg xor ovf) or zero. 2 is neg xor ovf. 3 is zero. 4 is not zero. 5 is not (neg xor ovf). 6 is not (neg xor ovf) and not zero.
- R9: Branch selectors 7 to 15 give not-taken.
- R10: With capture disabled, a clock edge leaves all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation selector |
| src_a | input | 32 | Operand A (source) |
| src_b | input | 32 | Operand B (destination) |
| cc_wr | input | 1 | Flag capture enable |
| br_sel | input | 4 | Branch condition selector |
| result | output | 32 | Operation result (combinational) |
| ovf | output | 1 | Stored overflow flag |
| zero | output | 1 | Stored zero flag |
| neg | output | 1 | Stored negative flag |
| br_taken | output | 1 | Branch condition outcome |

## Verification
The hardest situations to reach are the signed-overflow flag combinations under the less and greater conditions. Random 32-bit operands almost never produce an exactly-zero result, and they rarely produce overflow together with a negative result. The stimulus therefore mixes directed operand pairs at the signed limits (0x7FFFFFFF + 1, 0x80000000 - 1, and equal operands that subtract to zero) with random operands drawn from a small pool of edge values. After every capture, all sixteen branch selectors are swept against the newly stored flags.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
    localparam int unsigned SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3
    } op_e;

    typedef enum logic [SEL_W-1:0] {
        BR_ALWAYS = 4'd0,
        BR_LE     = 4'd1,
        BR_LT     = 4'd2,
        BR_EQ     = 4'd3,
        BR_NE     = 4'd4,
        BR_GE     = 4'd5,
        BR_GT     = 4'd6
    } br_e;

    typedef enum logic {
        CC_HOLD    = 1'b0,
        CC_CAPTURE = 1'b1
    } cc_act_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic neg;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{ovf: 1'b0, zero: 1'b1, neg: 1'b0};
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_cc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [SEL_W-1:0] op_sel,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic [WIDTH-1:0] result,
    output flags_t           flags_nxt,
    output logic             op_valid
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] diff;
    logic             add_ovf;
    logic             sub_ovf;

    assign sum     = src_b + src_a;
    assign diff    = src_b - src_a;
    assign add_ovf = (src_a[MSB] == src_b[MSB]) && (sum[MSB] != src_b[MSB]);
    assign sub_ovf = (src_a[MSB] != src_b[MSB]) && (diff[MSB] != src_b[MSB]);

    always_comb begin
        result   = '0;
        op_valid = 1'b1;
        flags_nxt.ovf = 1'b0;
        unique case (op_sel)
            OP_ADD: begin
                result        = sum;
                flags_nxt.ovf = add_ovf;
            end
            OP_SUB: begin
                result        = diff;
                flags_nxt.ovf = sub_ovf;
            end
            OP_AND:  result = src_b & src_a;
            OP_XOR:  result = src_b ^ src_a;
            default: op_valid = 1'b0;
        endcase
        flags_nxt.zero = (result == '0);
        flags_nxt.neg  = result[MSB];
    end
endmodule

// File: rtl/cc_register.sv
module cc_register
    import alu_cc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_req,
    input  flags_t flags_nxt,
    output flags_t flags_q
);
    cc_act_e act;

    always_comb begin
        act = wr_req ? CC_CAPTURE : CC_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= FLAGS_RESET;
        end else begin
            unique case (act)
                CC_CAPTURE: flags_q <= flags_nxt;
                CC_HOLD:    flags_q <= flags_q;
                default:    flags_q <= flags_q;
            endcase
        end
    end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import alu_cc_pkg::*;
(
    input  logic [SEL_W-1:0] br_sel,
    input  flags_t           flags_q,
    output logic             taken
);
    logic lt;

    assign lt = flags_q.neg ^ flags_q.ovf;

    always_comb begin
        taken = 1'b0;
        unique case (br_sel)
            BR_ALWAYS: taken = 1'b1;
            BR_LE:     taken = lt | flags_q.zero;
            BR_LT:     taken = lt;
            BR_EQ:     taken = flags_q.zero;
            BR_NE:     taken = ~flags_q.zero;
            BR_GE:     taken = ~lt;
            BR_GT:     taken = ~lt & ~flags_q.zero;
            default:   taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic             cc_wr,
    input  logic [3:0]       br_sel,
    output logic [WIDTH-1:0] result,
    output logic             ovf,
    output logic             zero,
    output logic             neg,
    output logic             br_taken
);
    flags_t flags_nxt;
    flags_t flags_q;
    logic   op_valid;

    alu_datapath #(.WIDTH(WIDTH)) u_dp (
        .op_sel    (op_sel),
        .src_a     (src_a),
        .src_b     (src_b),
        .result    (result),
        .flags_nxt (flags_nxt),
        .op_valid  (op_valid)
    );

    cc_register u_cc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (cc_wr & op_valid),
        .flags_nxt (flags_nxt),
        .flags_q   (flags_q)
    );

    branch_eval u_br (
        .br_sel  (br_sel),
        .flags_q (flags_q),
        .taken   (br_taken)
    );

    assign ovf  = flags_q.ovf;
    assign zero = flags_q.zero;
    assign neg  = flags_q.neg;
endmodule

// File: rtl/alu_cc_checker.sv
module alu_cc_checker #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             cc_wr,
    input logic [3:0]       br_sel,
    input logic             ovf,
    input logic             zero,
    input logic             neg,
    input logic             br_taken
);
    a_r4_bad_op_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd3) |-> (result == '0));

    a_r4_bad_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd3) |=> ($stable(ovf) && $stable(zero) && $stable(neg)));

    a_r10_no_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_wr |=> ($stable(ovf) && $stable(zero) && $stable(neg)));

    a_r5_zero_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_wr && op_sel <= 4'd3) |=> (zero == ($past(result) == '0)));

    a_r5_neg_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_wr && op_sel <= 4'd3) |=> (neg == $past(result[WIDTH-1])));

    a_r6_logic_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_wr && (op_sel == 4'd2 || op_sel == 4'd3)) |=> !ovf);

    a_r9_bad_br: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel > 4'd6) |-> !br_taken);

    a_r8_always: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel == 4'd0) |-> br_taken);

    a_r8_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel == 4'd3) |-> (br_taken == zero));
endmodule

bind alu_cc_unit alu_cc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sel   (op_sel),
    .result   (result),
    .cc_wr    (cc_wr),
    .br_sel   (br_sel),
    .ovf      (ovf),
    .zero     (zero),
    .neg      (neg),
    .br_taken (br_taken)
);

// File: tb/tb_alu_cc_unit.sv
module tb_alu_cc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        cc_wr = 1'b0;
    logic [3:0]  br_sel = '0;
    logic [31:0] result;
    logic        ovf, zero, neg, br_taken;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic m_ovf, m_zero, m_neg;

    always #4 clk = ~clk;

    alu_cc_unit dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
        .cc_wr(cc_wr), .br_sel(br_sel), .result(result), .ovf(ovf), .zero(zero),
        .neg(neg), .br_taken(br_taken)
    );

    function automatic logic [31:0] exp_res(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
        case (s)
            4'd0: return b + a;
            4'd1: return b - a;
            4'd2: return b & a;
            4'd3: return b ^ a;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
        logic signed [32:0] w;
        if (s == 4'd0) begin
            w = $signed({b[31], b}) + $signed({a[31], a});
            return w > 33'sd2147483647 || w < -33'sd2147483648;
        end
        if (s == 4'd1) begin
            w = $signed({b[31], b}) - $signed({a[31], a});
            return w > 33'sd2147483647 || w < -33'sd2147483648;
        end
        return 1'b0;
    endfunction

    function automatic logic exp_br(input logic [3:0] s, input logic o, input logic z, input logic n);
        case (s)
            4'd0: return 1'b1;
            4'd1: return (n != o) || z;
            4'd2: return n != o;
            4'd3: return z;
            4'd4: return !z;
            4'd5: return n == o;
            4'd6: return (n == o) && !z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b,
                        input logic w, input logic [3:0] j);
        string rtag;
        @(negedge clk);
        op_sel = s; src_a = a; src_b = b; cc_wr = w; br_sel = j;
        #1;
        rtag = (s == 4'd0) ? "R1" : (s == 4'd1) ? "R2" : (s <= 4'd3) ? "R3" : "R4";
        check(rtag, result, exp_res(s, a, b));
        check("R5 R6 R10 flags", {29'd0, ovf, zero, neg}, {29'd0, m_ovf, m_zero, m_neg});
        check((j > 4'd6) ? "R9" : "R8", {31'd0, br_taken}, {31'd0, exp_br(j, m_ovf, m_zero, m_neg)});
        @(posedge clk);
        if (w && s <= 4'd3) begin
            m_ovf  = exp_ovf(s, a, b);
            m_zero = (exp_res(s, a, b) == 32'd0);
            m_neg  = exp_res(s, a, b) >> 31;
        end
    endtask

    task automatic sweep_br;
        for (int j = 0; j < 16; j++) step(4'd15, 32'd0, 32'd0, 1'b1, j[3:0]);
    endtask

    function automatic logic [31:0] pick(input int unsigned r);
        case (r % 6)
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'h0000_0000;
            3: return 32'hFFFF_FFFF;
            4: return 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_ovf = 1'b0; m_zero = 1'b1; m_neg = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset flags", {29'd0, ovf, zero, neg}, 32'b010);
        @(negedge clk);
        rst_n = 1'b1;
        sweep_br();                                              // R8 R9 on reset flags
        step(4'd0, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 4'd2);    // R1 R6 add overflow
        sweep_br();
        step(4'd1, 32'h0000_0001, 32'h8000_0000, 1'b1, 4'd0);    // R2 R6 sub overflow
        sweep_br();
        step(4'd1, 32'h1234_5678, 32'h1234_5678, 1'b1, 4'd0);    // R5 zero result
        sweep_br();
        step(4'd1, 32'h0000_0005, 32'h0000_0003, 1'b1, 4'd0);    // negative, no overflow
        sweep_br();
        step(4'd0, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 4'd0);    // set OF
        step(4'd2, 32'hF0F0_F0F0, 32'hFFFF_0000, 1'b1, 4'd0);    // R3 R6 and clears OF
        step(4'd0, 32'h0000_0001, 32'h7FFF_FFFF, 1'b1, 4'd0);
        step(4'd3, 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 4'd0);    // R3 xor clears OF
        step(4'd9, 32'h1, 32'h1, 1'b1, 4'd3);                    // R4 bad op ignored
        step(4'd1, 32'd1, 32'd1, 1'b0, 4'd3);                    // R10 capture off
        step(4'd0, 32'd0, 32'd0, 1'b0, 4'd3);
        for (int i = 0; i < 400; i++) begin
            step($urandom % 16, pick($urandom), pick($urandom), $urandom % 2, $urandom % 16);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule